// File: doc/BRIEF.md
# Effective Privilege and Leaf Permission Checker

This block sits between a hart's load/store/fetch path and an external page-table walker. For every memory access it works out the privilege level that governs the access, from the access kind, the current privilege, the modify-privilege flag, the previous-privilege field, the user-page protection flag and a bare-translation flag. It then either bypasses translation altogether or judges the page-table entry that the walker supplies with the request.

A request is presented for one cycle together with its virtual address and the page-table entry for the current level. One cycle later the block returns one of three results:

- a bypass address, which is the virtual address truncated to the configured register width;
- a descend request, which carries the base of the next table level;
- a leaf result, which is either a physical address with no fault or a fault.

The walker uses the descend result to fetch the next level and then presents the request again with the new entry. The block does not sequence the walk, read memory, cache translations or update accessed/dirty bits.

Top module: `priv_perm_check`

## Requirements
- R1: Encodings used at the ports:
  - access kind: fetch=0, load=1, store=2;
  - privilege: user=0, supervisor=1, machine=3;
  - result kind: bypass=0, descend=1, leaf=2.

  A fetch always takes the current privilege as its effective privilege. The modify-privilege flag and the user-page protection flag have no effect on a fetch.
- R2: For a load or store with the modify-privilege flag set, the effective privilege is the previous-privilege field. With the flag clear, it is the current privilege.
- R3: User-page protection applies only to a load or store whose effective privilege is supervisor while the protection flag is set. Under it, a leaf entry that would grant the same access at user privilege faults. With the flag clear, the same access succeeds.
- R4: With the bare-translation flag set, the effective privilege is machine. The result is bypass with no fault, and the address is the virtual address with only its low XLEN bits kept and the bits above them zero.
- R5: When the effective privilege is machine and translation is not bare, the result is also bypass with the same XLEN truncation of the address.
- R6: The page-table entry has V at bit 0, R at bit 1, W at bit 2, X at bit 3, U at bit 4, and its frame number at bits starting at 10. An entry with V set and R, W and X all clear gives result descend, no fault, and an address equal to the frame number shifted left by 12.
- R7: An entry with V clear gives result leaf, fault set and address zero, whatever its other bits.
- R8: A leaf needs R for a load, W for a store and X for a fetch. At user effective privilege it also needs U set. At supervisor privilege U is not required, except as restricted by R3. Any fault reports result leaf with address zero.
- R9: A leaf that passes gives no fault and an address equal to the frame number shifted left by 12, ORed with the low 12 bits of the virtual address.
- R10: Every accepted request produces exactly one response on the following cycle, which also reports the effective privilege. The response valid is low in every other cycle and during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| acc_kind | input | 2 | Access kind (fetch/load/store) |
| cur_priv | input | 2 | Current privilege level |
| mod_priv | input | 1 | Data accesses use the previous-privilege field |
| prev_priv | input | 2 | Previous-privilege field |
| user_guard | input | 1 | Supervisor data access to user pages forbidden |
| xlat_bare | input | 1 | Translation is bare |
| vaddr | input | ADDR_W | Virtual address |
| pte | input | PTE_W | Page-table entry for the current level |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 2 | Result kind |
| rsp_addr | output | ADDR_W | Bypass address, next table base, or physical address |
| rsp_fault | output | 1 | Access fault |
| rsp_priv | output | 2 | Effective privilege of the access |

## Verification
Every result is due at the first clock edge after the edge that accepts its request. The bench therefore drives each request at a falling edge and pushes its expected result into a queue at the same moment. A monitor running on falling edges pops the queue whenever the response valid is high, so each response is compared exactly one cycle after its stimulus. A response with an empty queue, or entries left over at the end, counts as an error, which catches both missing and extra responses.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        RES_BYPASS  = 2'd0,
        RES_DESCEND = 2'd1,
        RES_LEAF    = 2'd2
    } res_kind_e;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int FLAG_W  = 5;
    localparam int PPN_LSB = 10;

    // flag bits: u=4, x=3, w=2, r=1, v=0
    typedef struct packed {
        logic u;
        logic x;
        logic w;
        logic r;
        logic v;
    } pte_flags_t;

    function automatic logic is_pointer(pte_flags_t f);
        return f.v & ~f.r & ~f.w & ~f.x;
    endfunction

    function automatic logic kind_granted(pte_flags_t f, acc_kind_e k);
        case (k)
            ACC_FETCH: return f.x;
            ACC_STORE: return f.w;
            default:   return f.r;
        endcase
    endfunction

    function automatic logic grants(pte_flags_t f, acc_kind_e k, logic as_user);
        return f.v & kind_granted(f, k) & (~as_user | f.u);
    endfunction

endpackage

// File: rtl/ppc_priv_sel.sv
module ppc_priv_sel
    import ppc_pkg::*;
(
    input  acc_kind_e  kind,
    input  logic [1:0] cur_priv,
    input  logic       mod_priv,
    input  logic [1:0] prev_priv,
    input  logic       user_guard,
    input  logic       xlat_bare,
    output logic [1:0] eff_priv,
    output logic       guard_active,
    output logic       bypass
);
    logic [1:0] req_priv;
    logic       is_data;

    always_comb begin
        is_data      = (kind != ACC_FETCH);
        req_priv     = (is_data && mod_priv) ? prev_priv : cur_priv;
        guard_active = is_data && (req_priv == PRIV_S) && user_guard;
        eff_priv     = xlat_bare ? PRIV_M : req_priv;
        bypass       = (eff_priv == PRIV_M);
    end
endmodule

// File: rtl/ppc_leaf_eval.sv
module ppc_leaf_eval
    import ppc_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int PTE_W      = 64,
    parameter int PPN_W      = 44,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [PTE_W-1:0]      pte,
    input  logic [PAGE_SHIFT-1:0] offset,
    input  acc_kind_e             kind,
    input  logic [1:0]            eff_priv,
    input  logic                  guard_active,
    output res_kind_e             res_kind,
    output logic [ADDR_W-1:0]     addr,
    output logic                  fault
);
    localparam int PPN_TOP = PPN_LSB + PPN_W;

    pte_flags_t          flags;
    logic [PPN_W-1:0]    ppn;
    logic [ADDR_W-1:0]   frame;
    logic                as_user;

    assign flags   = pte_flags_t'(pte[FLAG_W-1:0]);
    assign ppn     = pte[PPN_LSB +: PPN_W];
    assign as_user = (eff_priv == PRIV_U);

    always_comb begin
        frame = '0;
        frame[PAGE_SHIFT +: PPN_W] = ppn;
    end

    always_comb begin
        res_kind = RES_LEAF;
        fault    = 1'b0;
        addr     = '0;
        if (!flags.v) begin
            fault = 1'b1;
        end else if (is_pointer(flags)) begin
            res_kind = RES_DESCEND;
            addr     = frame;
        end else if (guard_active && grants(flags, kind, 1'b1)) begin
            fault = 1'b1;
        end else if (!grants(flags, kind, as_user)) begin
            fault = 1'b1;
        end else begin
            addr = frame;
            addr[PAGE_SHIFT-1:0] = offset;
        end
    end

    logic unused_pte_mid;
    assign unused_pte_mid = ^pte[PPN_LSB-1:FLAG_W];

    generate
        if (PTE_W > PPN_TOP) begin : g_hi
            logic unused_pte_hi;
            assign unused_pte_hi = ^pte[PTE_W-1:PPN_TOP];
        end
    endgenerate
endmodule

// File: rtl/priv_perm_check.sv
module priv_perm_check
    import ppc_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int XLEN       = 32,
    parameter int PTE_W      = 64,
    parameter int PPN_W      = 44,
    parameter int PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        acc_kind,
    input  logic [1:0]        cur_priv,
    input  logic              mod_priv,
    input  logic [1:0]        prev_priv,
    input  logic              user_guard,
    input  logic              xlat_bare,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [PTE_W-1:0]  pte,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_fault,
    output logic [1:0]        rsp_priv
);
    localparam int XL_KEEP = (XLEN < ADDR_W) ? XLEN : ADDR_W;
    localparam logic [ADDR_W-1:0] XMASK = {ADDR_W{1'b1}} >> (ADDR_W - XL_KEEP);

    acc_kind_e         kind;
    logic [1:0]        eff_priv;
    logic              guard_active;
    logic              bypass;
    res_kind_e         leaf_kind;
    logic [ADDR_W-1:0] leaf_addr;
    logic              leaf_fault;

    assign kind = acc_kind_e'(acc_kind);

    ppc_priv_sel u_sel (
        .kind        (kind),
        .cur_priv    (cur_priv),
        .mod_priv    (mod_priv),
        .prev_priv   (prev_priv),
        .user_guard  (user_guard),
        .xlat_bare   (xlat_bare),
        .eff_priv    (eff_priv),
        .guard_active(guard_active),
        .bypass      (bypass)
    );

    ppc_leaf_eval #(
        .ADDR_W    (ADDR_W),
        .PTE_W     (PTE_W),
        .PPN_W     (PPN_W),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) u_leaf (
        .pte         (pte),
        .offset      (vaddr[PAGE_SHIFT-1:0]),
        .kind        (kind),
        .eff_priv    (eff_priv),
        .guard_active(guard_active),
        .res_kind    (leaf_kind),
        .addr        (leaf_addr),
        .fault       (leaf_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_kind  <= RES_BYPASS;
            rsp_addr  <= '0;
            rsp_fault <= 1'b0;
            rsp_priv  <= PRIV_U;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_priv <= eff_priv;
                if (bypass) begin
                    rsp_kind  <= RES_BYPASS;
                    rsp_addr  <= vaddr & XMASK;
                    rsp_fault <= 1'b0;
                end else begin
                    rsp_kind  <= leaf_kind;
                    rsp_addr  <= leaf_addr;
                    rsp_fault <= leaf_fault;
                end
            end
        end
    end
endmodule

// File: rtl/ppc_checker.sv
module ppc_checker #(
    parameter int ADDR_W = 64,
    parameter int PTE_W  = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        acc_kind,
    input logic [1:0]        cur_priv,
    input logic              mod_priv,
    input logic [1:0]        prev_priv,
    input logic              xlat_bare,
    input logic [PTE_W-1:0]  pte,
    input logic              rsp_valid,
    input logic [1:0]        rsp_kind,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              rsp_fault,
    input logic [1:0]        rsp_priv
);
    AST_FETCH_CUR_PRIV: assert property (@(posedge clk) disable iff (rst)
        req_valid && acc_kind == 2'd0 && !xlat_bare |=> rsp_priv == $past(cur_priv)); // R1

    AST_DATA_PREV_PRIV: assert property (@(posedge clk) disable iff (rst)
        req_valid && acc_kind != 2'd0 && mod_priv && !xlat_bare |=> rsp_priv == $past(prev_priv)); // R2

    AST_BARE_BYPASS: assert property (@(posedge clk) disable iff (rst)
        req_valid && xlat_bare |=> rsp_kind == 2'd0 && rsp_priv == 2'd3 && !rsp_fault); // R4

    AST_POINTER_DESCENDS: assert property (@(posedge clk) disable iff (rst)
        req_valid && !xlat_bare && acc_kind == 2'd0 && cur_priv != 2'd3
        && pte[0] && pte[3:1] == 3'b000 |=> rsp_kind == 2'd1 && !rsp_fault); // R6

    AST_INVALID_FAULTS: assert property (@(posedge clk) disable iff (rst)
        req_valid && !xlat_bare && acc_kind == 2'd0 && cur_priv != 2'd3
        && !pte[0] |=> rsp_fault); // R7

    AST_FAULT_SHAPE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault |-> rsp_kind == 2'd2 && rsp_addr == '0); // R8

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R10

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R10
endmodule

bind priv_perm_check ppc_checker #(.ADDR_W(ADDR_W), .PTE_W(PTE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .acc_kind (acc_kind),
    .cur_priv (cur_priv),
    .mod_priv (mod_priv),
    .prev_priv(prev_priv),
    .xlat_bare(xlat_bare),
    .pte      (pte),
    .rsp_valid(rsp_valid),
    .rsp_kind (rsp_kind),
    .rsp_addr (rsp_addr),
    .rsp_fault(rsp_fault),
    .rsp_priv (rsp_priv)
);

// File: tb/sim_priv_perm_check.sv
module sim_priv_perm_check;
    localparam int ADDR_W = 64;
    localparam int XLEN   = 32;
    localparam int PTE_W  = 64;
    localparam int PPN_W  = 44;

    typedef struct packed {
        logic [1:0]        kind;
        logic [ADDR_W-1:0] addr;
        logic              fault;
        logic [1:0]        priv;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [1:0]        acc_kind = '0;
    logic [1:0]        cur_priv = '0;
    logic              mod_priv = 1'b0;
    logic [1:0]        prev_priv = '0;
    logic              user_guard = 1'b0;
    logic              xlat_bare = 1'b0;
    logic [ADDR_W-1:0] vaddr = '0;
    logic [PTE_W-1:0]  pte = '0;
    logic              rsp_valid;
    logic [1:0]        rsp_kind;
    logic [ADDR_W-1:0] rsp_addr;
    logic              rsp_fault;
    logic [1:0]        rsp_priv;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    priv_perm_check #(.ADDR_W(ADDR_W), .XLEN(XLEN), .PTE_W(PTE_W), .PPN_W(PPN_W)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .acc_kind(acc_kind),
        .cur_priv(cur_priv), .mod_priv(mod_priv), .prev_priv(prev_priv),
        .user_guard(user_guard), .xlat_bare(xlat_bare), .vaddr(vaddr), .pte(pte),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_addr(rsp_addr),
        .rsp_fault(rsp_fault), .rsp_priv(rsp_priv)
    );

    function automatic logic [PTE_W-1:0] mk_pte(bit v, bit r, bit w, bit x, bit u,
                                                 logic [PPN_W-1:0] ppn);
        logic [PTE_W-1:0] p;
        p = '0;
        p[10 +: PPN_W] = ppn;
        p[4:0] = {u, x, w, r, v};
        return p;
    endfunction

    function automatic exp_t model(logic [1:0] k, logic [1:0] cp, bit mp, logic [1:0] pp,
                                   bit ug, bit bare, logic [ADDR_W-1:0] va,
                                   logic [PTE_W-1:0] e);
        exp_t  r;
        logic [1:0] eff;
        bit    guard, need, user_ok, own_ok;
        logic [ADDR_W-1:0] frame;
        eff   = (k != 2'd0 && mp) ? pp : cp;
        guard = (k != 2'd0) && (eff == 2'd1) && ug;
        if (bare) eff = 2'd3;
        r.priv  = eff;
        r.fault = 1'b0;
        frame   = {{(ADDR_W-PPN_W-12){1'b0}}, e[10 +: PPN_W], 12'h000};
        need    = (k == 2'd0) ? e[3] : (k == 2'd2) ? e[2] : e[1];
        user_ok = e[0] && need && e[4];
        own_ok  = e[0] && need && ((eff == 2'd0) ? e[4] : 1'b1);
        if (eff == 2'd3) begin
            r.kind = 2'd0; r.addr = {32'h0, va[31:0]};
        end else if (!e[0]) begin
            r.kind = 2'd2; r.addr = '0; r.fault = 1'b1;
        end else if (e[3:1] == 3'b000) begin
            r.kind = 2'd1; r.addr = frame;
        end else if ((guard && user_ok) || !own_ok) begin
            r.kind = 2'd2; r.addr = '0; r.fault = 1'b1;
        end else begin
            r.kind = 2'd2; r.addr = frame | {52'h0, va[11:0]};
        end
        return r;
    endfunction

    task automatic send(string tag, logic [1:0] k, logic [1:0] cp, bit mp, logic [1:0] pp,
                        bit ug, bit bare, logic [ADDR_W-1:0] va, logic [PTE_W-1:0] e);
        @(negedge clk);
        req_valid = 1'b1; acc_kind = k; cur_priv = cp; mod_priv = mp; prev_priv = pp;
        user_guard = ug; xlat_bare = bare; vaddr = va; pte = e;
        exp_q.push_back(model(k, cp, mp, pp, ug, bare, va, e));
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // monitor: each response is compared one cycle after its request
    always @(negedge clk) begin
        if (!rst && rsp_valid && !done) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected response kind=%0d addr=%h expected none",
                         rsp_kind, rsp_addr);
            end else begin
                exp_t  x;
                string t;
                x = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rsp_kind !== x.kind || rsp_addr !== x.addr ||
                    rsp_fault !== x.fault || rsp_priv !== x.priv) begin
                    errors++;
                    $display("FAIL %s actual kind=%0d addr=%h fault=%0d priv=%0d expected kind=%0d addr=%h fault=%0d priv=%0d",
                             t, rsp_kind, rsp_addr, rsp_fault, rsp_priv,
                             x.kind, x.addr, x.fault, x.priv);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] va;
        va = 64'hFFFF_FFFF_8765_4ABC;
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset actual rsp_valid=%0d expected 0", rsp_valid);
        end
        rst = 1'b0;
        idle(1);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10 idle actual rsp_valid=%0d expected 0", rsp_valid);
        end

        send("R4 bare bypass",       2'd1, 2'd0, 0, 2'd0, 0, 1, va, mk_pte(1,1,1,1,1,44'h5));
        send("R5 machine fetch",     2'd0, 2'd3, 1, 2'd0, 1, 0, va, '0);
        send("R5 R2 mprv to machine",2'd1, 2'd1, 1, 2'd3, 0, 0, va, '0);
        send("R1 fetch user ignores mprv", 2'd0, 2'd0, 1, 2'd1, 1, 0, va, mk_pte(1,0,0,1,1,44'h123));
        send("R1 fetch sup ignores guard", 2'd0, 2'd1, 0, 2'd0, 1, 0, va, mk_pte(1,0,0,1,1,44'h124));
        send("R2 load via prev user",      2'd1, 2'd3, 1, 2'd0, 0, 0, va, mk_pte(1,1,0,0,1,44'h200));
        send("R2 R8 user needs U",         2'd1, 2'd3, 1, 2'd0, 0, 0, va, mk_pte(1,1,0,0,0,44'h200));
        send("R2 no mprv uses current",    2'd1, 2'd1, 0, 2'd0, 0, 0, va, mk_pte(1,1,0,0,0,44'h201));
        send("R3 guard load user page",    2'd1, 2'd1, 0, 2'd0, 1, 0, va, mk_pte(1,1,0,0,1,44'h300));
        send("R3 no guard load user page", 2'd1, 2'd1, 0, 2'd0, 0, 0, va, mk_pte(1,1,0,0,1,44'h300));
        send("R3 guard sup page",          2'd1, 2'd1, 0, 2'd0, 1, 0, va, mk_pte(1,1,0,0,0,44'h301));
        send("R3 guard store user page",   2'd2, 2'd1, 0, 2'd0, 1, 0, va, mk_pte(1,1,1,0,1,44'h302));
        send("R3 guard via prev sup",      2'd2, 2'd3, 1, 2'd1, 1, 0, va, mk_pte(1,1,1,0,1,44'h303));
        idle(2);
        send("R6 descend",         2'd1, 2'd1, 0, 2'd0, 0, 0, va, mk_pte(1,0,0,0,1,44'hABCDE));
        send("R7 invalid",         2'd0, 2'd0, 0, 2'd0, 0, 0, va, mk_pte(0,1,1,1,1,44'h77));
        send("R7 invalid pointer", 2'd1, 2'd1, 0, 2'd0, 0, 0, va, mk_pte(0,0,0,0,0,44'h78));
        send("R8 store needs W",   2'd2, 2'd1, 0, 2'd0, 0, 0, va, mk_pte(1,1,0,1,0,44'h400));
        send("R8 fetch needs X",   2'd0, 2'd1, 0, 2'd0, 0, 0, va, mk_pte(1,1,1,0,0,44'h401));
        send("R8 load needs R",    2'd1, 2'd0, 0, 2'd0, 0, 0, va, mk_pte(1,0,1,1,1,44'h402));
        send("R9 offset combine",  2'd2, 2'd0, 0, 2'd0, 0, 0, 64'h0000_0000_0000_0FFF,
             mk_pte(1,0,1,0,1,{PPN_W{1'b1}}));
        idle(1);
        for (int i = 0; i < 300; i++) begin
            logic [1:0] cp, pp, k;
            logic [PTE_W-1:0] e;
            k  = 2'($urandom % 3);
            cp = ($urandom % 3 == 0) ? 2'd3 : 2'($urandom % 2);
            pp = ($urandom % 3 == 0) ? 2'd3 : 2'($urandom % 2);
            e  = {$urandom, $urandom};
            send("R10 mixed sweep", k, cp, 1'($urandom), pp, 1'($urandom),
                 ($urandom % 8 == 0), {$urandom, $urandom}, e);
            if (i % 7 == 0) idle(1);
        end
        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10 missing responses actual %0d pending expected 0", exp_q.size());
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule